// File: doc/BRIEF.md
# Deduplicating Update Sorter

This block takes a group of updates per clock, one per lane, where each update names a destination index and carries a 32-bit value. It pushes the group through a pipelined bitonic network of compare-and-combine cells. When a cell sees two valid updates for the same destination, it folds them into one update holding the sum of the two values and frees the other slot. Updates with different destinations are exchanged so that each group leaves with its valid updates in ascending destination order. Fewer updates therefore reach the stage that writes them to memory, and they arrive in destination order.

Every column of cells is a register stage, so a group leaves the network a fixed number of cycles after it enters. One global stall input freezes every stage at once. A freed slot is marked invalid and keeps the destination it had, so the destinations across the lanes stay sorted. A lane that enters invalid is given the largest possible destination and drifts to the high end.

Top module: `cac_net`

## Requirements
- R1: While reset is high, and in the cycle after it, every output valid bit is 0.
- R2: A group presented with stall low appears at the outputs after exactly S rising edges, counting the capture edge, where S = L·(L+1)/2 and L = log2(LANES). S is 3 for LANES = 4. No valid update appears one cycle earlier.
- R3: Two valid updates with equal destinations that meet in a cell become one valid update whose value is their sum, and the other slot becomes invalid. When all lanes carry the same destination, lane 0 carries the single valid result and every other lane is invalid.
- R4: For every destination, the sum of the values of the valid outputs equals, modulo 2^32, the sum of the values of the valid inputs of the same group. No valid output carries a destination that was absent from the valid inputs.
- R5: Reading from lane 0 upward, the valid outputs have non-decreasing destinations.
- R6: An input lane with its valid bit at 0 contributes nothing: its destination and value never appear in a valid output, and they never change a sum.
- R7: Values are added as unsigned 32-bit numbers with wrap-around (0xFFFFFFFF + 2 gives 1).
- R8: While stall is high, all outputs hold their values and the input lanes are ignored. After stall falls, a group in flight resumes and leaves late by the number of stalled cycles.
- R9: A group of distinct destinations leaves with all its values unchanged, sorted by destination.
- R10: The number of valid outputs never exceeds the number of valid inputs of the same group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freezes all stages while high |
| in_vld | input | LANES | Per-lane update valid |
| in_dest | input | 32·LANES | Per-lane destination, lane i in bits [32i+31:32i] |
| in_val | input | 32·LANES | Per-lane value, lane i in bits [32i+31:32i] |
| out_vld | output | LANES | Per-lane result valid |
| out_dest | output | 32·LANES | Per-lane result destination, same packing |
| out_val | output | 32·LANES | Per-lane result value, same packing |

## Verification
Suppose a stage register holds a wrong value, or a cell picks the wrong direction or merge decision. The fault then shows up in the very cycle its group reaches the outputs, S cycles after capture. It appears as a per-destination total that does not match the input, as a destination out of order, or as more valid lanes than entered. A fault in the stall path shows up one cycle after stall rises, as an output that changes, or later as a group that arrives early, late or contaminated by lanes that were presented during the stall. The bench computes sums, order and counts from the inputs alone. It also checks the exact lane layout for groups with all-equal and all-distinct destinations.

// File: rtl/cac_pkg.sv
package cac_pkg;

    localparam int KEY_W = 32;
    localparam int VAL_W = 32;

    typedef struct packed {
        logic             vld;
        logic [KEY_W-1:0] dest;
        logic [VAL_W-1:0] val;
    } upd_t;

    // number of register columns for a bitonic network of the given width
    function automatic int stage_count(input int lanes);
        int lg;
        lg = $clog2(lanes);
        return (lg * (lg + 1)) / 2;
    endfunction

    // lower lane of cell c in a column whose partner distance is 2**s
    function automatic int cell_low(input int c, input int s);
        int blk;
        int off;
        blk = c >> s;
        off = c & ((1 << s) - 1);
        return (blk << (s + 1)) | off;
    endfunction

endpackage

// File: rtl/cac_cell.sv
module cac_cell
    import cac_pkg::*;
#(
    parameter bit ASCEND = 1'b1
) (
    input  upd_t a_i,
    input  upd_t b_i,
    output upd_t lo_o,
    output upd_t hi_o
);

    logic same_key;
    logic fold;
    logic swap;

    always_comb begin
        same_key = (a_i.dest == b_i.dest);
        fold     = a_i.vld && b_i.vld && same_key;
        if (ASCEND) begin
            swap = (a_i.dest > b_i.dest);
        end else begin
            swap = (a_i.dest < b_i.dest);
        end

        if (fold) begin
            lo_o.vld  = 1'b1;
            lo_o.dest = a_i.dest;
            lo_o.val  = a_i.val + b_i.val;
            // freed slot keeps its key so ordering stays intact
            hi_o.vld  = 1'b0;
            hi_o.dest = b_i.dest;
            hi_o.val  = '0;
        end else if (swap) begin
            lo_o = b_i;
            hi_o = a_i;
        end else begin
            lo_o = a_i;
            hi_o = b_i;
        end
    end

endmodule

// File: rtl/cac_stage.sv
module cac_stage
    import cac_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int DIST_LG = 0,
    parameter int BLK_LG  = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stall,
    input  upd_t [LANES-1:0]      d_i,
    output upd_t [LANES-1:0]      q_o
);

    localparam int CELLS = LANES / 2;
    localparam int DIST  = 1 << DIST_LG;

    upd_t nxt [LANES];

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        localparam int LO  = cell_low(c, DIST_LG);
        localparam int HI  = LO + DIST;
        localparam bit ASC = ((LO >> BLK_LG) & 1) == 0;

        cac_cell #(.ASCEND(ASC)) u_cell (
            .a_i  (d_i[LO]),
            .b_i  (d_i[HI]),
            .lo_o (nxt[LO]),
            .hi_o (nxt[HI])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (!stall) begin
            for (int i = 0; i < LANES; i++) begin
                q_o[i] <= nxt[i];
            end
        end
    end

endmodule

// File: rtl/cac_net.sv
module cac_net
    import cac_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stall,
    input  logic [LANES-1:0]         in_vld,
    input  logic [LANES*KEY_W-1:0]   in_dest,
    input  logic [LANES*VAL_W-1:0]   in_val,
    output logic [LANES-1:0]         out_vld,
    output logic [LANES*KEY_W-1:0]   out_dest,
    output logic [LANES*VAL_W-1:0]   out_val
);

    localparam int LG   = $clog2(LANES);
    localparam int NSTG = stage_count(LANES);

    upd_t [LANES-1:0] bus [NSTG+1];

    // idle lanes take the largest key so they settle at the top
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            bus[0][i].vld  = in_vld[i];
            bus[0][i].dest = in_vld[i] ? in_dest[i*KEY_W +: KEY_W] : '1;
            bus[0][i].val  = in_vld[i] ? in_val[i*VAL_W +: VAL_W]  : '0;
        end
    end

    for (genvar p = 0; p < LG; p++) begin : g_merge
        for (genvar j = 0; j <= p; j++) begin : g_col
            localparam int ST = (p * (p + 1)) / 2 + j;
            cac_stage #(
                .LANES   (LANES),
                .DIST_LG (p - j),
                .BLK_LG  (p + 1)
            ) u_stage (
                .clk   (clk),
                .rst   (rst),
                .stall (stall),
                .d_i   (bus[ST]),
                .q_o   (bus[ST+1])
            );
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            out_vld[i]                   = bus[NSTG][i].vld;
            out_dest[i*KEY_W +: KEY_W]   = bus[NSTG][i].dest;
            out_val[i*VAL_W +: VAL_W]    = bus[NSTG][i].val;
        end
    end

endmodule

// File: rtl/cac_net_chk.sv
module cac_net_chk
    import cac_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     stall,
    input logic [LANES-1:0]         in_vld,
    input logic [LANES*KEY_W-1:0]   in_dest,
    input logic [LANES*VAL_W-1:0]   in_val,
    input logic [LANES-1:0]         out_vld,
    input logic [LANES*KEY_W-1:0]   out_dest,
    input logic [LANES*VAL_W-1:0]   out_val
);

    localparam int NSTG = stage_count(LANES);
    localparam int CW   = $clog2(LANES + 1);

    logic [VAL_W-1:0] sum_pipe [NSTG];
    logic [CW-1:0]    cnt_pipe [NSTG];
    logic [VAL_W-1:0] in_sum;
    logic [VAL_W-1:0] out_sum;
    logic [CW-1:0]    in_cnt;
    logic [CW-1:0]    out_cnt;
    logic             ordered;

    always_comb begin
        logic             seen;
        logic [KEY_W-1:0] last;
        in_sum  = '0;
        out_sum = '0;
        in_cnt  = '0;
        out_cnt = '0;
        ordered = 1'b1;
        seen    = 1'b0;
        last    = '0;
        for (int i = 0; i < LANES; i++) begin
            if (in_vld[i]) begin
                in_sum = in_sum + in_val[i*VAL_W +: VAL_W];
                in_cnt = in_cnt + 1'b1;
            end
            if (out_vld[i]) begin
                out_sum = out_sum + out_val[i*VAL_W +: VAL_W];
                out_cnt = out_cnt + 1'b1;
                if (seen && (out_dest[i*KEY_W +: KEY_W] < last)) begin
                    ordered = 1'b0;
                end
                seen = 1'b1;
                last = out_dest[i*KEY_W +: KEY_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSTG; k++) begin
                sum_pipe[k] <= '0;
                cnt_pipe[k] <= '0;
            end
        end else if (!stall) begin
            sum_pipe[0] <= in_sum;
            cnt_pipe[0] <= in_cnt;
            for (int k = 1; k < NSTG; k++) begin
                sum_pipe[k] <= sum_pipe[k-1];
                cnt_pipe[k] <= cnt_pipe[k-1];
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_vld == '0));

    a_r4_total_kept: assert property (@(posedge clk) disable iff (rst)
        out_sum == sum_pipe[NSTG-1]);

    a_r10_no_growth: assert property (@(posedge clk) disable iff (rst)
        out_cnt <= cnt_pipe[NSTG-1]);

    a_r5_ascending: assert property (@(posedge clk) disable iff (rst)
        ordered);

    a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable({out_vld, out_dest, out_val}));

endmodule

bind cac_net cac_net_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .in_vld   (in_vld),
    .in_dest  (in_dest),
    .in_val   (in_val),
    .out_vld  (out_vld),
    .out_dest (out_dest),
    .out_val  (out_val)
);

// File: tb/sim_cac_net.sv
`timescale 1ns/1ps
module sim_cac_net;

    localparam int NL   = 4;
    localparam int LGN  = $clog2(NL);
    localparam int NSTG = (LGN * (LGN + 1)) / 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             stall = 1'b0;
    logic [NL-1:0]    in_vld = '0;
    logic [NL*32-1:0] in_dest = '0;
    logic [NL*32-1:0] in_val = '0;
    logic [NL-1:0]    out_vld;
    logic [NL*32-1:0] out_dest;
    logic [NL*32-1:0] out_val;

    int errors = 0;
    int checks = 0;

    logic [NL-1:0] sm;
    logic [31:0]   sd [NL];
    logic [31:0]   sv [NL];

    always #2 clk = ~clk;

    cac_net #(.LANES(NL)) u0 (
        .clk(clk), .rst(rst), .stall(stall),
        .in_vld(in_vld), .in_dest(in_dest), .in_val(in_val),
        .out_vld(out_vld), .out_dest(out_dest), .out_val(out_val)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] od(input int i);
        return out_dest[i*32 +: 32];
    endfunction

    function automatic logic [31:0] ov(input int i);
        return out_val[i*32 +: 32];
    endfunction

    task automatic set_lane(input int i, input logic m, input logic [31:0] d,
                            input logic [31:0] v);
        sm[i] = m;
        sd[i] = d;
        sv[i] = v;
    endtask

    // drive the staged group, capture it on one edge, then go idle
    task automatic push_group();
        @(negedge clk);
        stall = 1'b0;
        for (int i = 0; i < NL; i++) begin
            in_vld[i] = sm[i];
            in_dest[i*32 +: 32] = sd[i];
            in_val[i*32 +: 32]  = sv[i];
        end
        @(posedge clk);
        @(negedge clk);
        in_vld = '0;
    endtask

    task automatic wait_out();
        repeat (NSTG - 1) @(posedge clk);
        @(negedge clk);
    endtask

    // sums, order and count derived from the staged inputs only
    task automatic check_group(input string tag);
        int          n_in;
        int          n_out;
        logic        seen;
        logic [31:0] last;
        bit          ok_ord;
        n_in = 0;
        n_out = 0;
        seen = 1'b0;
        last = '0;
        ok_ord = 1'b1;
        for (int i = 0; i < NL; i++) begin
            if (sm[i]) n_in++;
            if (out_vld[i]) begin
                n_out++;
                if (seen && od(i) < last) ok_ord = 1'b0;
                seen = 1'b1;
                last = od(i);
            end
        end
        chk(n_out <= n_in, "R10", {tag, " valid count"}, n_out, n_in);
        chk(ok_ord, "R5", {tag, " order"}, last, last);
        for (int i = 0; i < NL; i++) begin
            if (sm[i]) begin
                logic [31:0] exp_s;
                logic [31:0] got_s;
                exp_s = '0;
                got_s = '0;
                for (int j = 0; j < NL; j++) begin
                    if (sm[j] && sd[j] == sd[i]) exp_s = exp_s + sv[j];
                    if (out_vld[j] && od(j) == sd[i]) got_s = got_s + ov(j);
                end
                chk(got_s == exp_s, "R4", {tag, " per-dest sum"}, got_s, exp_s);
            end
        end
        for (int j = 0; j < NL; j++) begin
            if (out_vld[j]) begin
                bit found;
                found = 1'b0;
                for (int i = 0; i < NL; i++) begin
                    if (sm[i] && sd[i] == od(j)) found = 1'b1;
                end
                chk(found, "R6", {tag, " no foreign dest"}, od(j), 32'h0);
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_vld == '0, "R1", "valid during reset", out_vld, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(out_vld == '0, "R1", "valid after reset", out_vld, 0);
    endtask

    task automatic t_all_same();
        set_lane(0, 1, 32'd7, 32'd1);
        set_lane(1, 1, 32'd7, 32'd2);
        set_lane(2, 1, 32'd7, 32'd3);
        set_lane(3, 1, 32'd7, 32'd4);
        push_group();
        repeat (NSTG - 2) @(posedge clk);
        @(negedge clk);
        chk(out_vld == '0, "R2", "early output", out_vld, 0);
        @(posedge clk);
        @(negedge clk);
        chk(out_vld == 4'b0001, "R3", "single survivor lanes", out_vld, 4'b0001);
        chk(ov(0) == 32'd10, "R3", "folded value", ov(0), 32'd10);
        chk(od(0) == 32'd7, "R3", "folded dest", od(0), 32'd7);
        check_group("same");
    endtask

    task automatic t_distinct();
        set_lane(0, 1, 32'd40, 32'hA0);
        set_lane(1, 1, 32'd30, 32'hB0);
        set_lane(2, 1, 32'd20, 32'hC0);
        set_lane(3, 1, 32'd10, 32'hD0);
        push_group();
        wait_out();
        chk(out_vld == 4'b1111, "R9", "all lanes valid", out_vld, 4'b1111);
        chk(od(0) == 32'd10 && ov(0) == 32'hD0, "R9", "lane0", ov(0), 32'hD0);
        chk(od(1) == 32'd20 && ov(1) == 32'hC0, "R9", "lane1", ov(1), 32'hC0);
        chk(od(2) == 32'd30 && ov(2) == 32'hB0, "R9", "lane2", ov(2), 32'hB0);
        chk(od(3) == 32'd40 && ov(3) == 32'hA0, "R9", "lane3", ov(3), 32'hA0);
        check_group("distinct");
    endtask

    task automatic t_pairs();
        set_lane(0, 1, 32'd5, 32'd11);
        set_lane(1, 1, 32'd9, 32'd22);
        set_lane(2, 1, 32'd5, 32'd33);
        set_lane(3, 1, 32'd9, 32'd44);
        push_group();
        wait_out();
        chk($countones(out_vld) == 2, "R3", "two pairs fold", $countones(out_vld), 2);
        check_group("pairs");
    endtask

    task automatic t_idle_lanes();
        set_lane(0, 1, 32'd5, 32'd1);
        set_lane(1, 0, 32'd5, 32'd100);
        set_lane(2, 1, 32'd5, 32'd2);
        set_lane(3, 0, 32'd77, 32'd200);
        push_group();
        wait_out();
        chk($countones(out_vld) == 1, "R6", "idle lanes dropped", $countones(out_vld), 1);
        check_group("idle");
    endtask

    task automatic t_wrap();
        set_lane(0, 1, 32'd3, 32'hFFFF_FFFF);
        set_lane(1, 1, 32'd3, 32'd2);
        set_lane(2, 0, 32'd0, 32'd0);
        set_lane(3, 0, 32'd0, 32'd0);
        push_group();
        wait_out();
        chk(out_vld[0] && ov(0) == 32'd1, "R7", "wrapped sum", ov(0), 32'd1);
        check_group("wrap");
    endtask

    task automatic t_stall_hold();
        logic [NL-1:0]    hv;
        logic [NL*32-1:0] hd;
        logic [NL*32-1:0] hval;
        set_lane(0, 1, 32'd8, 32'd80);
        set_lane(1, 1, 32'd2, 32'd20);
        set_lane(2, 1, 32'd6, 32'd60);
        set_lane(3, 1, 32'd2, 32'd25);
        push_group();
        wait_out();
        hv = out_vld;
        hd = out_dest;
        hval = out_val;
        stall = 1'b1;
        in_vld = '1;
        in_dest = {32'd1, 32'd1, 32'd1, 32'd1};
        in_val = {32'd9, 32'd9, 32'd9, 32'd9};
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(out_vld == hv && out_dest == hd && out_val == hval,
                "R8", "outputs frozen", out_val[31:0], hval[31:0]);
        end
        stall = 1'b0;
        in_vld = '0;
        repeat (NSTG) @(posedge clk);
        @(negedge clk);
        chk(out_vld == '0, "R8", "stalled input ignored", out_vld, 0);
    endtask

    task automatic t_stall_mid();
        set_lane(0, 1, 32'd15, 32'd3);
        set_lane(1, 1, 32'd12, 32'd4);
        set_lane(2, 1, 32'd15, 32'd5);
        set_lane(3, 0, 32'd0, 32'd0);
        push_group();
        stall = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        stall = 1'b0;
        repeat (NSTG - 2) @(posedge clk);
        @(negedge clk);
        chk(out_vld == '0, "R8", "no early exit after stall", out_vld, 0);
        @(posedge clk);
        @(negedge clk);
        chk(out_vld != '0, "R2", "delayed arrival", out_vld, 1);
        check_group("midstall");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_all_same();
        t_distinct();
        t_pairs();
        t_idle_lanes();
        t_wrap();
        t_stall_hold();
        t_stall_mid();
        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule